// File: doc/BRIEF.md
# Prioritized Interrupt Router with DMA Hand-off

This block gathers interrupt events from a set of peripheral sources and turns them into one prioritized request for the CPU. A rising edge on a source input latches a cause flag. Each source also has an interrupt enable bit, a DMA-route bit and a DMA-arm bit. The sources are split into equal groups, and each group carries a 3-bit priority level. Among the sources that are flagged, enabled and at a nonzero level, the arbiter picks the one with the highest level. It raises a request toward the CPU when that level is above the CPU's current level.

The CPU side is a three-state offer machine. `ST_IDLE` has no request out. In `ST_IDLE`, a qualifying winner causes the transition *capture* into `ST_POSTED`, which snapshots the vector and level. `ST_POSTED` holds that snapshot until the CPU pulses its acknowledge, which is the transition *accept* back to `ST_IDLE`. If software clears the captured source's flag or enable before the acknowledge, the transition *withdraw* moves to `ST_STALE`. That state keeps the request up but shows the fixed illegal vector 11 until *accept* returns it to `ST_IDLE`. The CPU therefore never samples a vector that changes partway through.

Some sources can be both routed and armed for DMA. An event on such a source pulses a DMA start line instead of setting the flag. A completion pulse from the DMA engine sets the source's flag, and so interrupts the CPU, only when the completion interrupt is enabled on the DMA side. A small register bus gives access to all state. A global mode bit chooses how writes act on the flag and DMA registers.

Top module: `irq_router`

## Requirements
- R1: After reset every register (flags, enables, DMA-route, DMA-arm, priorities, mode) reads 0, `irq_req` is low and `dma_start` is 0.
- R2: A rising edge on `src_evt[i]` sets flag i at the next clock edge. An input that is held high sets the flag only once, so a flag cleared while the input stays high remains clear.
- R3: With mode 0, a write to the flag register (address 0) clears each flag whose data bit is 1 and leaves the others unchanged. Writes to DMA-route (address 2) and DMA-arm (address 3) set each bit written with 1 and leave the others unchanged.
- R4: With mode 1 (bit 0 of address 5), a write to address 0, 2 or 3 loads the written value, so a written 0 clears the bit and a written 1 sets it.
- R5: A hardware set of a flag in the same cycle as a software clear of that flag leaves the flag set.
- R6: `irq_req` rises one clock after a flagged, enabled source exists whose group level is nonzero and strictly greater than `cpu_level`. A source at level 0 never raises a request.
- R7: The highest group level wins, and among equal levels the lowest source index wins. `irq_vec` = 16 + index and `irq_lvl` = level. Source i belongs to group i/(NSRC/NGRP), and group g's level sits in bits [4g+2:4g] of address 4; bit 4g+3 reads 0.
- R8: Once `irq_req` is up, it stays up and `irq_vec`/`irq_lvl` stay unchanged until `irq_ack`. If the captured source's flag or enable is cleared before `irq_ack`, `irq_vec` becomes 11 and stays 11 until `irq_ack`. `irq_ack` drops the request at the next edge.
- R9: An event on a source whose DMA-route and DMA-arm bits are both 1 gives a one-cycle pulse on `dma_start[i]` in the cycle after the edge is sampled, and the flag is not set. With DMA-arm 0, the event sets the flag as in R2.
- R10: A `dma_done[i]` pulse sets flag i when `dma_done_irq[i]` is 1, and has no effect when it is 0.
- R11: `rd_data` shows the register selected by `bus_addr` combinationally: 0 flags, 1 enables, 2 DMA-route, 3 DMA-arm, 4 priorities, 5 mode. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `bus_addr` |
| src_evt | input | 8 | Peripheral event inputs, rising-edge sensitive |
| dma_done | input | 8 | DMA completion pulses per source |
| dma_done_irq | input | 8 | Per-source completion interrupt enable from DMA side |
| dma_start | output | 8 | One-cycle DMA trigger per source |
| cpu_level | input | 4 | CPU's current interrupt level |
| irq_ack | input | 1 | CPU has latched vector and level |
| irq_req | output | 1 | Interrupt request to CPU |
| irq_vec | output | 8 | Vector number (16+index, or 11 if withdrawn) |
| irq_lvl | output | 4 | Level of the offered request |

## Verification
Any wrong flag, enable or priority bit shows up on `rd_data` in the same cycle its address is selected. It also shows up on `irq_req`/`irq_vec` one clock after the source would have won or lost arbitration. A wrong offer-state transition shows within one cycle: a dropped request, a changed vector before acknowledge, or a missing switch to vector 11. The reference model is compared against every output on every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POSTED = 2'd1,
        ST_STALE  = 2'd2
    } offer_st_t;

    localparam logic [7:0] ILLEGAL_VEC  = 8'd11;
    localparam int         FIELD_STRIDE = 4;

    localparam logic [2:0] A_FLAG = 3'd0;
    localparam logic [2:0] A_IEN  = 3'd1;
    localparam logic [2:0] A_DRTE = 3'd2;
    localparam logic [2:0] A_DARM = 3'd3;
    localparam logic [2:0] A_PRIO = 3'd4;
    localparam logic [2:0] A_MODE = 3'd5;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_router_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int NGRP = 4,
    parameter int LVLW = 3,
    parameter int DW   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [2:0]                 bus_addr,
    input  logic [DW-1:0]              bus_wdata,
    input  logic [NSRC-1:0]            src_evt,
    input  logic [NSRC-1:0]            dma_done,
    input  logic [NSRC-1:0]            dma_done_irq,
    output logic [NSRC-1:0]            flags,
    output logic [NSRC-1:0]            ien,
    output logic [NSRC-1:0]            drte,
    output logic [NSRC-1:0]            darm,
    output logic [NGRP-1:0][LVLW-1:0]  prio,
    output logic                       mode_rw,
    output logic [NSRC-1:0]            dma_start
);
    logic [NSRC-1:0] evt_prev, evt_edge, armed, hw_set, wsrc;
    logic [NSRC-1:0] flags_nx, ien_nx, drte_nx, darm_nx;
    logic [NGRP-1:0][LVLW-1:0] prio_nx;
    logic mode_nx;

    assign wsrc     = bus_wdata[NSRC-1:0];
    assign evt_edge = src_evt & ~evt_prev;
    assign armed    = drte & darm;
    assign hw_set   = (evt_edge & ~armed) | (dma_done & dma_done_irq);

    always_comb begin
        flags_nx = flags;
        ien_nx   = ien;
        drte_nx  = drte;
        darm_nx  = darm;
        prio_nx  = prio;
        mode_nx  = mode_rw;
        if (bus_wr) begin
            unique case (bus_addr)
                A_FLAG: flags_nx = mode_rw ? wsrc : (flags & ~wsrc);
                A_IEN:  ien_nx   = wsrc;
                A_DRTE: drte_nx  = mode_rw ? wsrc : (drte | wsrc);
                A_DARM: darm_nx  = mode_rw ? wsrc : (darm | wsrc);
                A_PRIO: begin
                    for (int g = 0; g < NGRP; g++)
                        prio_nx[g] = bus_wdata[g*FIELD_STRIDE +: LVLW];
                end
                A_MODE: mode_nx = bus_wdata[0];
                default: ;
            endcase
        end
        flags_nx = flags_nx | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_prev  <= '0;
            flags     <= '0;
            ien       <= '0;
            drte      <= '0;
            darm      <= '0;
            prio      <= '0;
            mode_rw   <= 1'b0;
            dma_start <= '0;
        end else begin
            evt_prev  <= src_evt;
            flags     <= flags_nx;
            ien       <= ien_nx;
            drte      <= drte_nx;
            darm      <= darm_nx;
            prio      <= prio_nx;
            mode_rw   <= mode_nx;
            dma_start <= evt_edge & armed;
        end
    end

    // R5: a hardware set survives a concurrent software clear
    a_r5_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set)));

    // R9: a DMA start only fires for a routed and armed source
    a_r9_start_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_start != '0) |-> (($past(drte & darm) & dma_start) == dma_start));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC = 8,
    parameter int NGRP = 4,
    parameter int LVLW = 3,
    localparam int IW  = $clog2(NSRC),
    localparam int GSZ = NSRC / NGRP
) (
    input  logic [NSRC-1:0]           flags,
    input  logic [NSRC-1:0]           ien,
    input  logic [NGRP-1:0][LVLW-1:0] prio,
    output logic                      win_valid,
    output logic [IW-1:0]             win_idx,
    output logic [LVLW-1:0]           win_lvl
);
    logic [NSRC-1:0][LVLW-1:0] src_lvl;

    for (genvar i = 0; i < NSRC; i++) begin : g_lvl
        assign src_lvl[i] = prio[i / GSZ];
    end

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (flags[i] && ien[i] && (src_lvl[i] > win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
                win_lvl   = src_lvl[i];
            end
        end
    end
endmodule

// File: rtl/irq_cpu_offer.sv
module irq_cpu_offer
    import irq_router_pkg::*;
#(
    parameter int NSRC          = 8,
    parameter int LVLW          = 3,
    parameter logic [7:0] VEC_BASE = 8'd16,
    localparam int IW           = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win_valid,
    input  logic [IW-1:0]   win_idx,
    input  logic [LVLW-1:0] win_lvl,
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] ien,
    input  logic [3:0]      cpu_level,
    input  logic            irq_ack,
    output logic            irq_req,
    output logic [7:0]      irq_vec,
    output logic [3:0]      irq_lvl
);
    offer_st_t       st, st_nx;
    logic [IW-1:0]   cap_idx;
    logic [LVLW-1:0] cap_lvl;
    logic            take, still_live;

    assign take       = win_valid && (4'(win_lvl) > cpu_level);
    assign still_live = flags[cap_idx] && ien[cap_idx];

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (take) st_nx = ST_POSTED;
            ST_POSTED: if (irq_ack) st_nx = ST_IDLE;
                       else if (!still_live) st_nx = ST_STALE;
            ST_STALE:  if (irq_ack) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cap_idx <= '0;
            cap_lvl <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && take) begin
                cap_idx <= win_idx;
                cap_lvl <= win_lvl;
            end
        end
    end

    always_comb begin
        irq_req = 1'b0;
        irq_vec = '0;
        irq_lvl = '0;
        unique case (st)
            ST_IDLE: ;
            ST_POSTED: begin
                irq_req = 1'b1;
                irq_vec = VEC_BASE + 8'(cap_idx);
                irq_lvl = 4'(cap_lvl);
            end
            ST_STALE: begin
                irq_req = 1'b1;
                irq_vec = ILLEGAL_VEC;
                irq_lvl = 4'(cap_lvl);
            end
            default: ;
        endcase
    end

    // R8: request held until acknowledged
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req);

    // R8: vector held, or replaced only by the illegal vector
    a_r8_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_vec == $past(irq_vec) || irq_vec == ILLEGAL_VEC));

    // R6: a new request is above the CPU level seen at capture
    a_r6_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (irq_lvl > $past(cpu_level)));

    // R6: level 0 never offered
    a_r6_lvl_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl != 4'd0));
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NSRC             = 8,
    parameter int NGRP             = 4,
    parameter int LVLW             = 3,
    parameter int DW               = 32,
    parameter logic [7:0] VEC_BASE = 8'd16,
    localparam int IW              = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [2:0]      bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   rd_data,
    input  logic [NSRC-1:0] src_evt,
    input  logic [NSRC-1:0] dma_done,
    input  logic [NSRC-1:0] dma_done_irq,
    output logic [NSRC-1:0] dma_start,
    input  logic [3:0]      cpu_level,
    input  logic            irq_ack,
    output logic            irq_req,
    output logic [7:0]      irq_vec,
    output logic [3:0]      irq_lvl
);
    logic [NSRC-1:0] flags, ien, drte, darm;
    logic [NGRP-1:0][LVLW-1:0] prio;
    logic mode_rw, win_valid;
    logic [IW-1:0] win_idx;
    logic [LVLW-1:0] win_lvl;

    irq_src_bank #(.NSRC(NSRC), .NGRP(NGRP), .LVLW(LVLW), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .src_evt(src_evt), .dma_done(dma_done),
        .dma_done_irq(dma_done_irq), .flags(flags), .ien(ien), .drte(drte),
        .darm(darm), .prio(prio), .mode_rw(mode_rw), .dma_start(dma_start)
    );

    irq_arbiter #(.NSRC(NSRC), .NGRP(NGRP), .LVLW(LVLW)) u_arb (
        .flags(flags), .ien(ien), .prio(prio),
        .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    irq_cpu_offer #(.NSRC(NSRC), .LVLW(LVLW), .VEC_BASE(VEC_BASE)) u_offer (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_idx(win_idx),
        .win_lvl(win_lvl), .flags(flags), .ien(ien), .cpu_level(cpu_level),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
    );

    always_comb begin
        rd_data = '0;
        unique case (bus_addr)
            A_FLAG: rd_data[NSRC-1:0] = flags;
            A_IEN:  rd_data[NSRC-1:0] = ien;
            A_DRTE: rd_data[NSRC-1:0] = drte;
            A_DARM: rd_data[NSRC-1:0] = darm;
            A_PRIO: begin
                for (int g = 0; g < NGRP; g++)
                    rd_data[g*FIELD_STRIDE +: LVLW] = prio[g];
            end
            A_MODE: rd_data[0] = mode_rw;
            default: ;
        endcase
    end
endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic [7:0]  src_evt = '0, dma_done = '0, dma_done_irq = '0, dma_start;
    logic [3:0]  cpu_level = '0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic [3:0]  irq_lvl;

    int total = 0, bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    irq_router u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .src_evt(src_evt),
        .dma_done(dma_done), .dma_done_irq(dma_done_irq), .dma_start(dma_start),
        .cpu_level(cpu_level), .irq_ack(irq_ack), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_lvl(irq_lvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] m_flag, m_ien, m_drte, m_darm, m_prev, m_start;
    logic [2:0] m_prio [4];
    logic       m_mode;
    int         m_st;          // 0 idle, 1 posted, 2 stale
    int         m_idx;
    int         m_lvl;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        logic [31:0] r = '0;
        case (a)
            3'd0: r[7:0] = m_flag;
            3'd1: r[7:0] = m_ien;
            3'd2: r[7:0] = m_drte;
            3'd3: r[7:0] = m_darm;
            3'd4: for (int g = 0; g < 4; g++) r[g*4 +: 3] = m_prio[g];
            3'd5: r[0] = m_mode;
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0; m_ien = 0; m_drte = 0; m_darm = 0; m_prev = 0; m_start = 0;
            for (int g = 0; g < 4; g++) m_prio[g] = 0;
            m_mode = 0; m_st = 0; m_idx = 0; m_lvl = 0;
        end else begin
            logic [7:0] edg, setv;
            int best, bidx;
            // offer machine on pre-edge state
            case (m_st)
                0: begin
                    best = 0; bidx = 0;
                    for (int i = 0; i < 8; i++)
                        if (m_flag[i] && m_ien[i] && int'(m_prio[i/2]) > best) begin
                            best = int'(m_prio[i/2]); bidx = i;
                        end
                    if (best > 0 && best > int'(cpu_level)) begin
                        m_st = 1; m_idx = bidx; m_lvl = best;
                    end
                end
                1: if (irq_ack) m_st = 0;
                   else if (!(m_flag[m_idx] && m_ien[m_idx])) m_st = 2;
                default: if (irq_ack) m_st = 0;
            endcase
            edg = src_evt & ~m_prev;
            m_prev = src_evt;
            m_start = edg & m_drte & m_darm;
            setv = (edg & ~(m_drte & m_darm)) | (dma_done & dma_done_irq);
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_flag = m_mode ? bus_wdata[7:0] : (m_flag & ~bus_wdata[7:0]);
                    3'd1: m_ien = bus_wdata[7:0];
                    3'd2: m_drte = m_mode ? bus_wdata[7:0] : (m_drte | bus_wdata[7:0]);
                    3'd3: m_darm = m_mode ? bus_wdata[7:0] : (m_darm | bus_wdata[7:0]);
                    3'd4: for (int g = 0; g < 4; g++) m_prio[g] = bus_wdata[g*4 +: 3];
                    3'd5: m_mode = bus_wdata[0];
                    default: ;
                endcase
            end
            m_flag = m_flag | setv;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6 irq_req model", 32'(irq_req), 32'(m_st != 0));
            chk("R7/R8 irq_vec model", 32'(irq_vec),
                m_st == 0 ? 32'd0 : (m_st == 2 ? 32'd11 : 32'(16 + m_idx)));
            chk("R7 irq_lvl model", 32'(irq_lvl), m_st == 0 ? 32'd0 : 32'(m_lvl));
            chk("R9 dma_start model", 32'(dma_start), 32'(m_start));
            chk("R11 rd_data model", rd_data, m_read(bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #3 bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #3 bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(posedge clk); #3 src_evt = m;
        @(posedge clk); #3 src_evt = 0;
    endtask

    task automatic ack_to(input logic [3:0] lvl);
        @(posedge clk); #3 irq_ack = 1; cpu_level = lvl;
        @(posedge clk); #3 irq_ack = 0;
    endtask

    task automatic see_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        #1 bus_addr = a; #2 chk(tag, rd_data, e);
    endtask

    task automatic see_irq(input logic r, input logic [7:0] v, input logic [3:0] l, input string tag);
        #4;
        chk({tag, " req"}, 32'(irq_req), 32'(r));
        if (r) begin
            chk({tag, " vec"}, 32'(irq_vec), 32'(v));
            chk({tag, " lvl"}, 32'(irq_lvl), 32'(l));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        for (int a = 0; a < 6; a++) see_rd(3'(a), 32'd0, "R1 reset reg");
        see_irq(1'b0, 8'd0, 4'd0, "R1 reset");
        chk("R1 dma_start reset", 32'(dma_start), 32'd0);

        // R7/R11 priority field masking
        wr(3'd4, 32'hFFFF_FFFF);
        see_rd(3'd4, 32'h0000_7777, "R7 prio mask");
        wr(3'd4, 32'h0000_0553);              // g0=3 g1=5 g2=5 g3=0
        wr(3'd1, 32'h0000_00FF);
        see_rd(3'd1, 32'h0000_00FF, "R11 ien readback");

        // R2/R6 single source
        pulse(8'h01); cyc(2);
        see_irq(1'b1, 8'd16, 4'd3, "R6 single source");
        see_rd(3'd0, 32'h01, "R2 flag set");
        ack_to(4'd3);
        wr(3'd0, 32'h00);
        see_rd(3'd0, 32'h01, "R3 write 0 keeps flag");
        wr(3'd0, 32'h01);
        see_rd(3'd0, 32'h00, "R3 write 1 clears flag");
        cpu_level = 0; cyc(2);
        see_irq(1'b0, 8'd0, 4'd0, "R3 nothing pending");

        // R7 tie at level 5: index 2 beats index 4
        pulse(8'h14); cyc(2);
        see_irq(1'b1, 8'd18, 4'd5, "R7 tie lower index");
        ack_to(4'd5);
        wr(3'd0, 32'h04); cyc(2);
        see_irq(1'b0, 8'd0, 4'd0, "R6 equal to cpu level");
        cpu_level = 0; cyc(2);
        see_irq(1'b1, 8'd20, 4'd5, "R7 next source");
        ack_to(4'd5); wr(3'd0, 32'h10); cpu_level = 0;

        // R7 higher level beats lower index
        pulse(8'h09); cyc(2);
        see_irq(1'b1, 8'd19, 4'd5, "R7 higher level wins");
        ack_to(4'd5); wr(3'd0, 32'h08); cyc(2);
        see_irq(1'b0, 8'd0, 4'd0, "R6 lower level masked");
        cpu_level = 0; cyc(2);
        see_irq(1'b1, 8'd16, 4'd3, "R7 remaining low source");
        ack_to(4'd3); wr(3'd0, 32'h01); cpu_level = 0;

        // R6 level 0 group never requests
        pulse(8'h40); cyc(3);
        see_irq(1'b0, 8'd0, 4'd0, "R6 level zero");
        see_rd(3'd0, 32'h40, "R6 level zero flag");
        wr(3'd0, 32'h40);

        // R8 withdrawal gives illegal vector
        pulse(8'h02); cyc(2);
        see_irq(1'b1, 8'd17, 4'd3, "R8 posted");
        cyc(3);
        see_irq(1'b1, 8'd17, 4'd3, "R8 held");
        wr(3'd0, 32'h02); cyc(1);
        see_irq(1'b1, 8'd11, 4'd3, "R8 withdrawn");
        ack_to(4'd0); cyc(1);
        see_irq(1'b0, 8'd0, 4'd0, "R8 after ack");

        // R5 set beats concurrent clear
        @(posedge clk); #3 src_evt = 8'h02; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 32'h02;
        @(posedge clk); #3 src_evt = 0; bus_wr = 0; bus_wdata = 0;
        see_rd(3'd0, 32'h02, "R5 set over clear");
        cyc(1);
        ack_to(4'd3); wr(3'd0, 32'h02); cpu_level = 0;

        // R2 held-high input sets once
        @(posedge clk); #3 src_evt = 8'h80;
        cyc(2);
        see_rd(3'd0, 32'h80, "R2 held sets");
        wr(3'd0, 32'h80); cyc(3);
        see_rd(3'd0, 32'h00, "R2 held no re-set");
        src_evt = 0; cyc(1);

        // R3 set-only DMA regs, R9 routing
        wr(3'd2, 32'h20); wr(3'd3, 32'h20);
        wr(3'd2, 32'h00);
        see_rd(3'd2, 32'h20, "R3 route set-only");
        @(posedge clk); #3 src_evt = 8'h20;
        @(posedge clk); #7 chk("R9 dma_start pulse", 32'(dma_start), 32'h20);
        #6 src_evt = 0;
        @(posedge clk); #7 chk("R9 dma_start one cycle", 32'(dma_start), 32'h00);
        see_rd(3'd0, 32'h00, "R9 no flag when routed");
        see_irq(1'b0, 8'd0, 4'd0, "R9 no cpu request");

        // R10 completion
        @(posedge clk); #3 dma_done = 8'h20; dma_done_irq = 8'h00;
        @(posedge clk); #3 dma_done = 0;
        see_rd(3'd0, 32'h00, "R10 completion irq off");
        @(posedge clk); #3 dma_done = 8'h20; dma_done_irq = 8'h20;
        @(posedge clk); #3 dma_done = 0; dma_done_irq = 0;
        see_rd(3'd0, 32'h20, "R10 completion irq on");
        cyc(1);
        see_irq(1'b1, 8'd21, 4'd5, "R10 completion request");
        ack_to(4'd7); wr(3'd0, 32'h20);

        // R4 read/write mode
        wr(3'd5, 32'h1);
        see_rd(3'd5, 32'h1, "R4 mode set");
        wr(3'd3, 32'h00);
        see_rd(3'd3, 32'h00, "R4 arm cleared by 0");
        pulse(8'h20); cyc(1);
        see_rd(3'd0, 32'h20, "R9 unarmed sets flag");
        chk("R9 unarmed no start", 32'(dma_start), 32'h0);
        wr(3'd0, 32'h01);
        see_rd(3'd0, 32'h01, "R4 flag loads value");
        wr(3'd0, 32'h00);
        see_rd(3'd0, 32'h00, "R4 flag 0 clears");
        wr(3'd2, 32'h00);
        see_rd(3'd2, 32'h00, "R4 route cleared");
        bus_addr = 3'd6; #1 chk("R11 unused address", rd_data, 32'h0);
        cpu_level = 0; cyc(4);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule